// File: doc/BRIEF.md
# Edge-Kicked Watchdog With Periodic Alarm

This block watches a single activity line driven by a processor. Each change of level on that line, whether it rises or falls, counts as a kick and restarts an internal timeout count. If the count runs out before a kick, the active-low alarm output drops. As long as the processor stays silent after that, the alarm repeats as a train of low pulses of fixed width and fixed period. The train stops at the next kick.

Three side inputs shape the behaviour. A supply-low flag pulls the alarm low at once and keeps it there. When the flag clears, the alarm is released on the next clock with no stretch. A clear request, such as a manual reset, restarts the count the same way a kick does. A line-valid flag says whether anything drives the activity line. While that flag is low, the timeout is switched off and only supply-low can pull the alarm down.

All durations are counted in ticks of a free-running prescaler, so they can be set to seconds in silicon and to a few cycles in simulation. The activity line is asynchronous and passes through a synchronizer. All other inputs are synchronous to the clock.

Top module: `edge_watchdog`

## Requirements
- R1: During and right after the synchronous active-high `rst`, `wd_alarm_n` is 1 and the timeout count is zero.
- R2: A rising edge and a falling edge on `wd_line` are each a kick. A kick restarts the timeout count from zero. The kick acts at the third rising clock edge after the new level is first sampled: two synchronizer flops, then a compare with the previous synchronized level.
- R3: With `wd_line_valid`=1, `supply_low`=0 and no kick or clear, `wd_alarm_n` goes to 0 on the clock at which the TIMEOUT_TICKS-th tick since the last restart is counted.
- R4: After expiry, and with no kick, `wd_alarm_n` repeats a pattern of PULSE_PERIOD_TICKS ticks. It is 0 for the first PULSE_LOW_TICKS ticks of each period and 1 for the rest. It changes only on tick clocks.
- R5: A kick during the alarm train sets `wd_alarm_n` to 1 on the next clock and starts a fresh timeout from zero.
- R6: `clear_req`=1 for one clock restarts the timeout count exactly as a kick does, including during the alarm train.
- R7: `supply_low`=1 gives `wd_alarm_n`=0 on the next clock. This has priority over kicks, clears and the line-valid flag, and it holds the count at zero.
- R8: The clock after `supply_low` returns to 0, `wd_alarm_n` is 1. The timeout then restarts from zero, with no tick counted on that clock.
- R9: While `wd_line_valid`=0 and `supply_low`=0, `wd_alarm_n` stays 1 however long the line is idle. When the flag returns to 1, the timeout restarts from zero.
- R10: A pulse on `wd_line` that is two clocks wide gives two kicks, one for its rising edge and one for its falling edge.
- R11: The prescaler raises one tick every TICK_DIV clocks. It runs freely from reset and is not restarted by kicks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_line | input | 1 | Asynchronous activity line from the processor |
| wd_line_valid | input | 1 | 1 when the activity line is driven; 0 turns the timeout off |
| supply_low | input | 1 | Supply-low flag; forces the alarm low |
| clear_req | input | 1 | Restarts the timeout count, for example on a manual reset |
| wd_alarm_n | output | 1 | Active-low alarm: low after expiry as a pulse train, and low during supply-low |

## Verification
The assertions assume that `supply_low`, `wd_line_valid` and `clear_req` change only between clock edges. They also assume that PULSE_LOW_TICKS is below PULSE_PERIOD_TICKS and that TIMEOUT_TICKS is at least one. Only `wd_line` may be asynchronous, and it is seen only through the synchronizer. The bench drives every input on the falling clock edge and holds each `wd_line` level for at least two clocks. It uses short tick counts, so expiry, several alarm periods, recovery from supply-low and re-enable all occur within one run.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        WD_RUN    = 2'd0,
        WD_ALARM  = 2'd1,
        WD_SUPPLY = 2'd2,
        WD_OFF    = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic kick;
        logic tick;
        logic clr;
        logic sup_low;
        logic line_ok;
    } wd_ctl_t;

    function automatic int cnt_bits(int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    function automatic logic phase_is_low(int unsigned phase, int unsigned low_len);
        return phase < low_len;
    endfunction

endpackage

// File: rtl/wdg_tick.sv
module wdg_tick #(
    parameter int TICK_DIV = 125000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [W-1:0] pre_q;
            assign tick = (pre_q == W'(TICK_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst)       pre_q <= '0;
                else if (tick) pre_q <= '0;
                else           pre_q <= pre_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/wdg_edge.sv
module wdg_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic kick
);
    localparam int N = SYNC_STAGES + 1;

    logic [N-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[N-2:0], line_in};
    end

    assign kick = sh_q[N-1] ^ sh_q[N-2];
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int TIMEOUT_TICKS      = 1600,
    parameter int PULSE_LOW_TICKS    = 220,
    parameter int PULSE_PERIOD_TICKS = 1900
) (
    input  logic                                clk,
    input  logic                                rst,
    input  wd_ctl_t                             ctl,
    output wd_state_e                           state,
    output logic [cnt_bits(TIMEOUT_TICKS)-1:0]  cnt,
    output logic                                alarm_n
);
    localparam int CW = cnt_bits(TIMEOUT_TICKS);
    localparam int PW = cnt_bits(PULSE_PERIOD_TICKS);

    wd_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [PW-1:0] phase_q, phase_d, phase_nx;
    logic          out_q, out_d;

    assign phase_nx = (phase_q == PW'(PULSE_PERIOD_TICKS - 1)) ? '0 : phase_q + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        phase_d = phase_q;
        out_d   = out_q;
        if (ctl.sup_low) begin
            state_d = WD_SUPPLY;
            cnt_d   = '0;
            phase_d = '0;
            out_d   = 1'b0;
        end else if (!ctl.line_ok) begin
            state_d = WD_OFF;
            cnt_d   = '0;
            phase_d = '0;
            out_d   = 1'b1;
        end else if (ctl.kick || ctl.clr || state_q == WD_SUPPLY || state_q == WD_OFF) begin
            state_d = WD_RUN;
            cnt_d   = '0;
            phase_d = '0;
            out_d   = 1'b1;
        end else if (ctl.tick) begin
            if (state_q == WD_RUN) begin
                if (cnt_q == CW'(TIMEOUT_TICKS - 1)) begin
                    state_d = WD_ALARM;
                    cnt_d   = '0;
                    phase_d = '0;
                    out_d   = 1'b0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end else begin
                phase_d = phase_nx;
                out_d   = !phase_is_low(int'(phase_nx), PULSE_LOW_TICKS);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_RUN;
            cnt_q   <= '0;
            phase_q <= '0;
            out_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            phase_q <= phase_d;
            out_q   <= out_d;
        end
    end

    assign state   = state_q;
    assign cnt     = cnt_q;
    assign alarm_n = out_q;
endmodule

// File: rtl/edge_watchdog.sv
module edge_watchdog
    import wdg_pkg::*;
#(
    parameter int TICK_DIV           = 125000,
    parameter int TIMEOUT_TICKS      = 1600,
    parameter int PULSE_LOW_TICKS    = 220,
    parameter int PULSE_PERIOD_TICKS = 1900,
    parameter int SYNC_STAGES        = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wd_line,
    input  logic wd_line_valid,
    input  logic supply_low,
    input  logic clear_req,
    output logic wd_alarm_n
);
    localparam int CNT_W = cnt_bits(TIMEOUT_TICKS);

    logic             tick_w;
    logic             kick_w;
    wd_ctl_t          ctl_w;
    wd_state_e        state_w;
    logic [CNT_W-1:0] cnt_w;

    wdg_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick_w)
    );

    wdg_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_in(wd_line),
        .kick   (kick_w)
    );

    assign ctl_w = '{kick: kick_w, tick: tick_w, clr: clear_req,
                     sup_low: supply_low, line_ok: wd_line_valid};

    wdg_core #(
        .TIMEOUT_TICKS     (TIMEOUT_TICKS),
        .PULSE_LOW_TICKS   (PULSE_LOW_TICKS),
        .PULSE_PERIOD_TICKS(PULSE_PERIOD_TICKS)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl_w),
        .state  (state_w),
        .cnt    (cnt_w),
        .alarm_n(wd_alarm_n)
    );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int TICK_DIV = 4,
    parameter int TIMEOUT  = 10,
    parameter int CW       = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          supply_low,
    input logic          line_ok,
    input logic          clear_req,
    input logic          kick,
    input logic          tick,
    input wd_state_e     state,
    input logic [CW-1:0] cnt,
    input logic          wdo_n
);
    AST_RESET_RELEASED: assert property (@(posedge clk) rst |=> (wdo_n && cnt == '0)); // R1

    AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (kick && !supply_low && line_ok) |=> (cnt == '0 && wdo_n)); // R2

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(TIMEOUT)); // R3

    AST_TRAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state == WD_ALARM && !tick && !kick && !clear_req && line_ok && !supply_low)
        |=> $stable(wdo_n)); // R4

    AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !supply_low && line_ok) |=> (cnt == '0 && wdo_n)); // R6

    AST_SUPPLY_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> (!wdo_n && cnt == '0)); // R7

    AST_SUPPLY_RECOVERY: assert property (@(posedge clk) disable iff (rst)
        $fell(supply_low) |=> wdo_n); // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!line_ok && !supply_low) |=> wdo_n); // R9

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (TICK_DIV > 1 && tick) |=> !tick); // R11
endmodule

bind edge_watchdog wdg_checker #(
    .TICK_DIV(TICK_DIV),
    .TIMEOUT (TIMEOUT_TICKS),
    .CW      (CNT_W)
) u_wdg_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_low(supply_low),
    .line_ok   (wd_line_valid),
    .clear_req (clear_req),
    .kick      (kick_w),
    .tick      (tick_w),
    .state     (state_w),
    .cnt       (cnt_w),
    .wdo_n     (wd_alarm_n)
);

// File: tb/test_edge_watchdog.sv
module test_edge_watchdog;
    localparam int DIV = 4;
    localparam int TO  = 10;
    localparam int LOW = 3;
    localparam int PER = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wd_line = 1'b0;
    logic wd_line_valid = 1'b1;
    logic supply_low = 1'b0;
    logic clear_req = 1'b0;
    logic wd_alarm_n;

    int checks = 0;
    int errs = 0;
    bit chk_on = 1'b0;
    bit finished = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    edge_watchdog #(
        .TICK_DIV(DIV), .TIMEOUT_TICKS(TO),
        .PULSE_LOW_TICKS(LOW), .PULSE_PERIOD_TICKS(PER)
    ) i_edge_watchdog (
        .clk(clk), .rst(rst), .wd_line(wd_line), .wd_line_valid(wd_line_valid),
        .supply_low(supply_low), .clear_req(clear_req), .wd_alarm_n(wd_alarm_n)
    );

    // behavioural reference: ticks since last restart, pattern from arithmetic
    int m_pre;
    int m_since;
    bit m_restart;
    bit m_exp;
    bit hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_since = 0; m_restart = 0; m_exp = 1;
            hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit tk, ed;
            tk = (m_pre == DIV - 1);
            m_pre = tk ? 0 : m_pre + 1;
            ed = (hist[1] != hist[2]);
            hist.push_front(wd_line);
            void'(hist.pop_back());
            if (supply_low) begin
                m_since = 0; m_restart = 1; m_exp = 0;
            end else if (!wd_line_valid) begin
                m_since = 0; m_restart = 1; m_exp = 1;
            end else if (ed || clear_req || m_restart) begin
                m_since = 0; m_restart = 0; m_exp = 1;
            end else begin
                if (tk) m_since++;
                m_exp = !(m_since >= TO && ((m_since - TO) % PER) < LOW);
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: wd_alarm_n=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (chk_on && !rst) check(wd_alarm_n, m_exp, cur_req);

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_run();
    end

    initial begin
        clocks(4);
        check(wd_alarm_n, 1'b1, "R1");
        rst = 1'b0;
        clocks(1);
        check(wd_alarm_n, 1'b1, "R1");
        chk_on = 1'b1;

        cur_req = "R2";
        for (int i = 0; i < 12; i++) begin
            clocks(20);
            wd_line = ~wd_line;
        end
        clocks(5);
        check(wd_alarm_n, 1'b1, "R2");

        cur_req = "R3 R4 R11";
        clocks(130);

        cur_req = "R5";
        wd_line = ~wd_line;
        clocks(30);
        check(wd_alarm_n, 1'b1, "R5");
        cur_req = "R3 R4";
        clocks(70);

        cur_req = "R10";
        for (int i = 0; i < 5; i++) begin
            wd_line = ~wd_line;
            clocks(2);
            wd_line = ~wd_line;
            clocks(30);
        end
        check(wd_alarm_n, 1'b1, "R10");

        cur_req = "R6";
        for (int i = 0; i < 5; i++) begin
            clear_req = 1'b1;
            clocks(1);
            clear_req = 1'b0;
            clocks(30);
        end
        check(wd_alarm_n, 1'b1, "R6");
        clocks(70);
        clear_req = 1'b1;
        clocks(1);
        clear_req = 1'b0;
        clocks(1);
        check(wd_alarm_n, 1'b1, "R6");
        clocks(90);

        cur_req = "R7";
        supply_low = 1'b1;
        clocks(1);
        check(wd_alarm_n, 1'b0, "R7");
        for (int i = 0; i < 4; i++) begin
            wd_line = ~wd_line;
            clear_req = 1'b1;
            clocks(1);
            clear_req = 1'b0;
            clocks(10);
        end
        wd_line_valid = 1'b0;
        clocks(5);
        check(wd_alarm_n, 1'b0, "R7");
        wd_line_valid = 1'b1;
        clocks(5);

        cur_req = "R8";
        supply_low = 1'b0;
        clocks(1);
        check(wd_alarm_n, 1'b1, "R8");
        clocks(80);

        cur_req = "R9";
        wd_line_valid = 1'b0;
        clocks(200);
        check(wd_alarm_n, 1'b1, "R9");
        supply_low = 1'b1;
        clocks(3);
        check(wd_alarm_n, 1'b0, "R9 R7");
        supply_low = 1'b0;
        clocks(50);
        check(wd_alarm_n, 1'b1, "R9");
        wd_line_valid = 1'b1;
        clocks(100);

        cur_req = "R1";
        rst = 1'b1;
        clocks(3);
        check(wd_alarm_n, 1'b1, "R1");
        rst = 1'b0;
        clocks(20);

        chk_on = 1'b0;
        finish_run();
    end
endmodule